// File: doc/BRIEF.md
# Master Clock Divider with Interrupt Boost

This block produces the master clock for a CPU and its buses. It can take that clock from a main oscillator, a PLL or a 32.768 kHz real-time clock. It divides the chosen source by a power of two between 1 and 1024. Switching between sources is glitch-free. A change of divisor waits for the end of the current output period, so the output never carries a shortened pulse. The output is gated from the source clock: at a divide ratio of 2^e it passes one full source high phase in every 2^e source cycles.

Software writes a configuration word through a single-cycle write strobe that is synchronous to the oscillator clock. The word holds the source code, the divisor exponent and a boost enable. When boost is enabled and the interrupt-active flag rises, the divider drops to a ratio of 1 at once, without waiting for a period boundary. It holds full speed until the interrupt-done flag is seen, then returns to the programmed exponent. Status outputs in the oscillator domain report the source actually driving the output, the exponent in force and whether boost is engaged.

Top module: `mclk_gen`

## Requirements
- R1: After reset the main oscillator is the source, the exponent is 0 and boost is off; the status reads source 0, exponent 0, boost 0, and mclk_o gives one pulse per oscillator cycle.
- R2: With exponent e in force on a steady source, mclk_o gives exactly one pulse per 2^e source cycles, and stat_exp_o reads e.
- R3: A written exponent above 10 is stored as 10; the status then reads 10 and the ratio is 1024.
- R4: The exponent in force changes only at the end of a divided period or on a boost entry or exit, never in mid-period.
- R5: Every high phase of mclk_o is one complete high phase of one source clock, and at no time is more than one source enabled.
- R6: Source codes are 0 for the oscillator, 1 for the PLL and 2 for the real-time clock; after a switch, mclk_o runs at the new source rate and stat_src_o reports the new code.
- R7: A write with source code 3 leaves the source unchanged; its exponent and boost fields still take effect.
- R8: With boost enabled, a high irq_active_i brings mclk_o to one pulse per source cycle within five source cycles; the status reads boost 1 and exponent 0.
- R9: A high irq_done_i while boosted ends the boost and restores the programmed exponent.
- R10: With boost disabled, irq_active_i has no effect on the ratio or on stat_boost_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Main oscillator clock; also clocks the configuration and status logic |
| clk_pll_i | input | 1 | PLL clock |
| clk_rtc_i | input | 1 | 32.768 kHz real-time clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_src_i | input | 2 | Source code: 0 oscillator, 1 PLL, 2 real-time clock, 3 ignored |
| cfg_exp_i | input | 4 | Divisor exponent; ratio is 2^exp, clamped to 10 |
| cfg_boost_en_i | input | 1 | Enables the interrupt boost |
| irq_active_i | input | 1 | An interrupt is being serviced |
| irq_done_i | input | 1 | Interrupt servicing has ended |
| mclk_o | output | 1 | Divided master clock |
| stat_src_o | output | 2 | Code of the source currently driving mclk_o |
| stat_exp_o | output | 4 | Exponent currently in force |
| stat_boost_o | output | 1 | Boost engaged |

## Verification
A configuration write needs two source-clock edges to cross into the divider. It then waits for the end of the old divided period, which is up to 2^old_e source cycles. The status takes two more oscillator edges. A source switch needs two edges of the old clock and then two of the new clock before the first new pulse. The bench therefore waits for these worst-case latencies, measured in cycles of the source concerned, before reading the status or counting pulses. Pulse counts are taken over windows that span a whole number of divided periods and begin half a source period after a source edge, so no output edge falls on a window boundary. The interrupt boost is measured over a window that opens five source cycles after irq_active_i rises.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int NUM_SRC = 3;
  // source index doubles as the written source code
  typedef enum logic [1:0] {
    SRC_OSC  = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_RTC  = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;
endpackage

// File: rtl/mclk_sync.sv
module mclk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mclk_cfg_regs.sv
module mclk_cfg_regs
  import mclk_pkg::*;
#(
  parameter int EXP_MAX     = 10,
  parameter int SYNC_STAGES = 2,
  localparam int EXP_W      = $clog2(EXP_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         src_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic               boost_en_i,
  output logic [NUM_SRC-1:0] sel_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic               boost_en_o,
  input  logic [NUM_SRC-1:0] act_en_i,
  input  logic [EXP_W-1:0]   act_exp_i,
  input  logic               act_boost_i,
  output logic [1:0]         stat_src_o,
  output logic [EXP_W-1:0]   stat_exp_o,
  output logic               stat_boost_o
);
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(EXP_MAX);

  logic [NUM_SRC-1:0] sel_q;
  logic [EXP_W-1:0]   exp_q;
  logic               boost_en_q;
  logic [EXP_W-1:0]   exp_clamped;
  logic               src_valid;

  assign exp_clamped = (exp_i > EXP_LIM) ? EXP_LIM : exp_i;
  assign src_valid   = (src_i != SRC_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= NUM_SRC'(1) << SRC_OSC;
      exp_q      <= '0;
      boost_en_q <= 1'b0;
    end else if (we_i) begin
      if (src_valid) sel_q <= NUM_SRC'(1) << src_i;
      exp_q      <= exp_clamped;
      boost_en_q <= boost_en_i;
    end
  end

  assign sel_o      = sel_q;
  assign exp_o      = exp_q;
  assign boost_en_o = boost_en_q;

  // status from foreign domains; fields are quasi-static
  logic [NUM_SRC-1:0] en_s;
  logic [EXP_W:0]     div_s;
  logic [1:0]         stat_src_q;

  mclk_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(act_en_i), .q_o(en_s));

  mclk_sync #(.W(EXP_W + 1), .STAGES(SYNC_STAGES)) u_div_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({act_boost_i, act_exp_i}), .q_o(div_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             stat_src_q <= SRC_OSC;
    else if (en_s[SRC_RTC])  stat_src_q <= SRC_RTC;
    else if (en_s[SRC_PLL])  stat_src_q <= SRC_PLL;
    else if (en_s[SRC_OSC])  stat_src_q <= SRC_OSC;
  end

  assign stat_src_o   = stat_src_q;
  assign stat_exp_o   = div_s[EXP_W-1:0];
  assign stat_boost_o = div_s[EXP_W];

  // R3
  exp_reg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q <= EXP_LIM);

  // R7
  rsvd_src_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && src_i == SRC_RSVD) |=> $stable(sel_q));
endmodule

// File: rtl/mclk_src_mux.sv
module mclk_src_mux
  import mclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_SRC-1:0] clks_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] sel_i,
  output logic               clk_o,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] gated;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [NUM_SRC-1:0] SELF = NUM_SRC'(1) << g;
    logic req, req_s, en_q;

    // enable only once every other branch has dropped
    assign req = sel_i[g] & ~|(en_o & ~SELF);

    mclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i(clks_i[g]), .rst_ni(rst_ni), .d_i(req), .q_o(req_s));

    // change enable while this clock is low
    always_ff @(negedge clks_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= req_s;
    end

    assign en_o[g]  = en_q;
    assign gated[g] = clks_i[g] & en_q;
  end

  assign clk_o = |gated;

  // R5
  src_en_onehot_chk: assert property (@(posedge clks_i[SRC_OSC]) disable iff (!rst_ni)
    $onehot0(en_o));
endmodule

// File: rtl/mclk_div.sv
module mclk_div #(
  parameter int EXP_MAX  = 10,
  localparam int EXP_W   = $clog2(EXP_MAX + 1),
  localparam int CNT_W   = (EXP_MAX > 0) ? EXP_MAX : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXP_W-1:0] tgt_exp_i,
  input  logic             boost_en_i,
  input  logic             irq_act_i,
  input  logic             irq_done_i,
  output logic             mclk_o,
  output logic [EXP_W-1:0] cur_exp_o,
  output logic             boost_o
);
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(EXP_MAX);

  logic [CNT_W-1:0] cnt_q, period_m1;
  logic [EXP_W-1:0] cur_exp_q, tgt_exp;
  logic             boost_q, at_bound, boost_set, boost_clr;
  logic             gate_d, gate_lat;

  assign tgt_exp = (tgt_exp_i > EXP_LIM) ? EXP_LIM : tgt_exp_i;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) period_m1[i] = (i < int'(cur_exp_q));
  end

  assign at_bound  = (cnt_q == period_m1);
  assign boost_set = boost_en_i & irq_act_i & ~boost_q;
  assign boost_clr = boost_q & (irq_done_i | ~boost_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      cur_exp_q <= '0;
      boost_q   <= 1'b0;
    end else if (boost_set) begin
      // boost bypasses the boundary wait
      boost_q   <= 1'b1;
      cur_exp_q <= '0;
      cnt_q     <= '0;
    end else if (boost_clr) begin
      boost_q   <= 1'b0;
      cur_exp_q <= tgt_exp;
      cnt_q     <= '0;
    end else if (at_bound) begin
      cnt_q     <= '0;
      cur_exp_q <= boost_q ? '0 : tgt_exp;
    end else begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  assign gate_d = (cnt_q == '0);

  // transparent while clock low: gating cannot clip a high phase
  always_latch begin
    if (!clk_i) gate_lat = gate_d;
  end

  assign mclk_o    = clk_i & gate_lat;
  assign cur_exp_o = cur_exp_q;
  assign boost_o   = boost_q;

  // R3
  cur_exp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_exp_q <= EXP_LIM);

  // R4
  exp_change_at_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_exp_q != $past(cur_exp_q)) |-> ($past(at_bound) || $past(boost_set) || $past(boost_clr)));

  // R8
  boost_full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_q |-> (cur_exp_q == '0));
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
  import mclk_pkg::*;
#(
  parameter int EXP_MAX     = 10,
  parameter int SYNC_STAGES = 2,
  localparam int EXP_W      = $clog2(EXP_MAX + 1)
) (
  input  logic             clk_osc_i,
  input  logic             clk_pll_i,
  input  logic             clk_rtc_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_src_i,
  input  logic [EXP_W-1:0] cfg_exp_i,
  input  logic             cfg_boost_en_i,
  input  logic             irq_active_i,
  input  logic             irq_done_i,
  output logic             mclk_o,
  output logic [1:0]       stat_src_o,
  output logic [EXP_W-1:0] stat_exp_o,
  output logic             stat_boost_o
);
  logic [NUM_SRC-1:0] clks, sel, src_en;
  logic [EXP_W-1:0]   cfg_exp, cur_exp;
  logic               cfg_boost_en, cur_boost, clk_src;
  logic [EXP_W+2:0]   ctl_s;

  assign clks[SRC_OSC] = clk_osc_i;
  assign clks[SRC_PLL] = clk_pll_i;
  assign clks[SRC_RTC] = clk_rtc_i;

  mclk_cfg_regs #(.EXP_MAX(EXP_MAX), .SYNC_STAGES(SYNC_STAGES)) u_cfg (
    .clk_i        (clk_osc_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .src_i        (cfg_src_i),
    .exp_i        (cfg_exp_i),
    .boost_en_i   (cfg_boost_en_i),
    .sel_o        (sel),
    .exp_o        (cfg_exp),
    .boost_en_o   (cfg_boost_en),
    .act_en_i     (src_en),
    .act_exp_i    (cur_exp),
    .act_boost_i  (cur_boost),
    .stat_src_o   (stat_src_o),
    .stat_exp_o   (stat_exp_o),
    .stat_boost_o (stat_boost_o)
  );

  mclk_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clks_i (clks),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .clk_o  (clk_src),
    .en_o   (src_en)
  );

  // controls into the selected-source domain
  mclk_sync #(.W(EXP_W + 3), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk_i  (clk_src),
    .rst_ni (rst_ni),
    .d_i    ({irq_done_i, irq_active_i, cfg_boost_en, cfg_exp}),
    .q_o    (ctl_s)
  );

  mclk_div #(.EXP_MAX(EXP_MAX)) u_div (
    .clk_i      (clk_src),
    .rst_ni     (rst_ni),
    .tgt_exp_i  (ctl_s[EXP_W-1:0]),
    .boost_en_i (ctl_s[EXP_W]),
    .irq_act_i  (ctl_s[EXP_W+1]),
    .irq_done_i (ctl_s[EXP_W+2]),
    .mclk_o     (mclk_o),
    .cur_exp_o  (cur_exp),
    .boost_o    (cur_boost)
  );
endmodule

// File: tb/mclk_gen_test.sv
`timescale 1ns/1ps
module mclk_gen_test;
  localparam real P_OSC = 10.0;
  localparam real P_PLL = 4.0;
  localparam real P_RTC = 64.0;

  logic clk_osc = 0, clk_pll = 0, clk_rtc = 0, rst_n = 0;
  logic we = 0, boost_en = 0, irq_act = 0, irq_done = 0;
  logic [1:0] src = 0;
  logic [3:0] expw = 0;
  logic mclk;
  logic [1:0] st_src;
  logic [3:0] st_exp;
  logic st_boost;

  int n_chk = 0, n_fail = 0;
  int pulse_total = 0, runt_bad = 0, highs_seen = 0;
  bit done = 0;
  realtime t_rise = -1.0, t_fall = -1.0;

  always #(P_OSC/2) clk_osc = ~clk_osc;
  always #(P_PLL/2) clk_pll = ~clk_pll;
  always #(P_RTC/2) clk_rtc = ~clk_rtc;

  mclk_gen uut (
    .clk_osc_i(clk_osc), .clk_pll_i(clk_pll), .clk_rtc_i(clk_rtc), .rst_ni(rst_n),
    .cfg_we_i(we), .cfg_src_i(src), .cfg_exp_i(expw), .cfg_boost_en_i(boost_en),
    .irq_active_i(irq_act), .irq_done_i(irq_done), .mclk_o(mclk),
    .stat_src_o(st_src), .stat_exp_o(st_exp), .stat_boost_o(st_boost));

  // pulse counter and runt monitor (R5)
  always @(posedge mclk) begin
    pulse_total++;
    if (t_fall >= 0.0 && ($realtime - t_fall) < P_PLL/2 - 0.01) runt_bad++;
    t_rise = $realtime;
  end
  always @(negedge mclk) begin
    realtime hw;
    hw = $realtime - t_rise;
    highs_seen++;
    if (!((hw > 1.99 && hw < 2.01) || (hw > 4.99 && hw < 5.01) || (hw > 31.99 && hw < 32.01)))
      runt_bad++;
    t_fall = $realtime;
  end

  function automatic int clamp_ref(input int e);
    return (e > 10) ? 10 : e;
  endfunction

  function automatic real per(input int idx);
    return (idx == 1) ? P_PLL : (idx == 2) ? P_RTC : P_OSC;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input int s, input int e, input bit b);
    @(negedge clk_osc);
    we = 1; src = s[1:0]; expw = e[3:0]; boost_en = b;
    @(negedge clk_osc);
    we = 0;
  endtask

  // worst-case latency: syncs plus end of old period, then status sync
  task automatic settle(input int idx, input int old_e);
    #(((2 ** old_e) + 12) * per(idx));
    repeat (8) @(negedge clk_osc);
  endtask

  task automatic measure(input int idx, input int e, input int m, input string req);
    int s0;
    case (idx)
      1: @(posedge clk_pll);
      2: @(posedge clk_rtc);
      default: @(posedge clk_osc);
    endcase
    #(per(idx) / 2);
    s0 = pulse_total;
    #(per(idx) * m * (2 ** e));
    chk(pulse_total - s0 == m, req, pulse_total - s0, m);
  endtask

  task automatic chk_stat(input int s, input int e, input int b, input string req);
    chk(st_src == s[1:0], req, st_src, s);
    chk(st_exp == e[3:0], req, st_exp, e);
    chk(st_boost == b[0], req, st_boost, b);
  endtask

  initial begin
    int cur_e;
    void'($urandom(32'h5eed_c10c));
    #47 rst_n = 1;
    repeat (20) @(negedge clk_osc);

    // R1 reset state
    chk_stat(0, 0, 0, "R1");
    measure(0, 0, 32, "R1");

    // R2 / R3 random exponents on the oscillator
    cur_e = 0;
    for (int i = 0; i < 8; i++) begin
      int e;
      e = $urandom % 16;
      wr(0, e, 0);
      settle(0, cur_e);
      cur_e = clamp_ref(e);
      chk(st_exp == cur_e[3:0], (e > 10) ? "R3" : "R2", st_exp, cur_e);
      measure(0, cur_e, (cur_e >= 8) ? 2 : 4, (e > 10) ? "R3" : "R2");
    end

    // R3 directed clamp
    wr(0, 15, 0);
    settle(0, cur_e);
    cur_e = 10;
    chk(st_exp == 4'd10, "R3", st_exp, 10);
    measure(0, 10, 2, "R3");
    wr(0, 2, 0);
    settle(0, cur_e);
    cur_e = 2;
    measure(0, 2, 8, "R2");

    // R6 switch to PLL
    wr(1, 0, 0);
    settle(0, cur_e);
    repeat (20) @(negedge clk_osc);
    chk_stat(1, 0, 0, "R6");
    measure(1, 0, 50, "R6");
    wr(1, 3, 0);
    settle(1, 0);
    measure(1, 3, 4, "R2");

    // R7 reserved source code
    wr(3, 1, 0);
    settle(1, 3);
    chk(st_src == 2'd1, "R7", st_src, 1);
    chk(st_exp == 4'd1, "R7", st_exp, 1);
    measure(1, 1, 10, "R7");

    // R6 switch to the real-time clock
    wr(2, 1, 0);
    #(20 * P_RTC);
    repeat (8) @(negedge clk_osc);
    chk_stat(2, 1, 0, "R6");
    measure(2, 1, 4, "R6");

    // back to the oscillator
    wr(0, 6, 1);
    #(20 * P_RTC);
    settle(0, 6);
    chk_stat(0, 6, 0, "R6");
    measure(0, 6, 3, "R2");

    // R8 boost entry
    @(negedge clk_osc);
    irq_act = 1;
    repeat (5) @(posedge clk_osc);
    measure(0, 0, 20, "R8");
    chk_stat(0, 0, 1, "R8");

    // R9 boost exit
    @(negedge clk_osc);
    irq_act = 0;
    irq_done = 1;
    repeat (4) @(negedge clk_osc);
    irq_done = 0;
    settle(0, 0);
    chk_stat(0, 6, 0, "R9");
    measure(0, 6, 3, "R9");

    // R10 boost disabled
    wr(0, 6, 0);
    settle(0, 6);
    @(negedge clk_osc);
    irq_act = 1;
    repeat (10) @(negedge clk_osc);
    chk(st_boost == 1'b0, "R10", st_boost, 0);
    chk(st_exp == 4'd6, "R10", st_exp, 6);
    measure(0, 6, 3, "R10");
    irq_act = 0;

    // R5 no runt pulses over the whole run
    chk(runt_bad == 0, "R5", runt_bad, 0);
    chk(highs_seen > 0, "R5", highs_seen, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule